// File: doc/BRIEF.md
# DRAM Command Priority Scheduler

This block picks at most one DRAM command per clock cycle for a controller serving eight banks. Five requester classes compete. Refresh and scrub requests come from two internal interval timers. Column (CAS) commands, reads and writes come from per-bank request vectors on the ports. The classes are served in a fixed priority order. Inside a class, the lowest bank number wins. The issued command, its bank and a one-hot grant are all driven combinationally in the same cycle as the requests that produce them.

Reads and writes open a row, so each of them counts as a row activation. A sliding history of recent cycles holds row activations within a four-in-a-window budget. A read is also held back while its 32-bit address matches the address of any write that is still requested. The read goes out once that write has been granted and the host has dropped it. Both interval reload values come from configuration inputs that are written at startup and held constant afterwards. Each requester keeps its request asserted until it sees its grant.

Top module: `dram_cmd_sched`

## Requirements
- R1: At most one grant bit is set in any cycle (grant bit 0 refresh, 1 CAS, 2 scrub, 3 read, 4 write). The command code matches the grant: 0 no command, 1 refresh, 2 CAS, 3 scrub, 4 activate-read, 5 activate-write. With no grant, the code is 0 and the bank is 0.
- R2: Eligible classes are served in strict order: refresh, then CAS, then scrub, then read, then write.
- R3: The refresh timer loads `cfg_ref_ivl` in reset and counts down one per cycle. Refresh is due once the count reaches zero and stays due until granted. A grant reloads the count. A refresh reports bank 0.
- R4: The scrub timer behaves the same way, using `cfg_scrub_ivl`. Each scrub targets the bank after the one the previous scrub used, wrapping from 7 to 0, and starts at bank 0 after reset.
- R5: Read and write grants are row activations. Neither may be granted while 4 activations already fall within the previous T_FAW-1 cycles. As a result, no window of T_FAW (16) consecutive cycles holds more than 4 activations.
- R6: A read whose address equals the address of any asserted write request is not granted. Other reads, and writes, remain eligible.
- R7: Within CAS, read and write, the lowest-numbered eligible bank is granted and reported on `cmd_bank`.
- R8: While reset is asserted, no grant is given and the command code is 0, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ref_ivl | input | 13 | Refresh interval reload value |
| cfg_scrub_ivl | input | 12 | Scrub interval reload value |
| cas_req | input | 8 | Per-bank CAS request |
| rd_req | input | 8 | Per-bank read request |
| rd_addr | input | 256 | Read address of each bank, bank b in bits b*32 upward |
| wr_req | input | 8 | Per-bank write request |
| wr_addr | input | 256 | Write address of each bank, bank b in bits b*32 upward |
| cmd_out | output | 3 | Issued command code |
| cmd_bank | output | 3 | Bank of the issued command |
| grant | output | 5 | One-hot grant per requester class |

## Verification
The hardest situation to reach is a blocked read caught between two other limits: the activation window is full, and refresh or scrub falls due while the write it waits on keeps losing to higher classes. The stimulus draws read and write addresses from a pool of only six values, so hazards are frequent. It runs at a request rate high enough to fill the window again and again, while short timer intervals make refresh and scrub collide with that traffic. Directed phases come before the random phase. One floods all eight banks with reads to fill the window. Another sets up a hazard by hand, where one read must wait behind a write while another read overtakes both.

// File: rtl/dram_sched_pkg.sv
`timescale 1ns/1ps
package dram_sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_REF    = 3'd1,
    CMD_CAS    = 3'd2,
    CMD_SCRUB  = 3'd3,
    CMD_ACT_RD = 3'd4,
    CMD_ACT_WR = 3'd5
  } sched_cmd_e;

  // grant vector bit positions, also the priority order (low index wins)
  localparam int G_REF   = 0;
  localparam int G_CAS   = 1;
  localparam int G_SCRUB = 2;
  localparam int G_READ  = 3;
  localparam int G_WRITE = 4;
  localparam int NREQ    = 5;

endpackage

// File: rtl/sched_interval_timer.sv
`timescale 1ns/1ps
module sched_interval_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload,
  input  logic         take,
  output logic         due
);

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                               input logic [W-1:0] r,
                                               input logic         t);
    if (t)              return r;
    else if (c != '0)   return c - W'(1);
    else                return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= reload;
    else        cnt <= next_count(cnt, reload, take);
  end

  assign due = (cnt == '0);

  AST_DUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !take) |=> due);                                  // R3
  AST_RELOAD_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt == $past(reload)));                         // R4

endmodule

// File: rtl/sched_act_window.sv
`timescale 1ns/1ps
module sched_act_window #(
  parameter int WIN   = 16,
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_fire,
  output logic act_block
);

  localparam int HW = WIN - 1;
  localparam int CW = $clog2(HW + 1) + 1;

  logic [HW-1:0] hist;

  function automatic logic [CW-1:0] ones_in(input logic [HW-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < HW; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  generate
    if (HW == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= act_fire;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HW-2:0], act_fire};
      end
    end
  endgenerate

  logic [CW-1:0] recent;
  assign recent    = ones_in(hist);
  assign act_block = (recent >= CW'(LIMIT));

  AST_FAW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> (recent < CW'(LIMIT)));                      // R5

endmodule

// File: rtl/sched_raw_check.sv
`timescale 1ns/1ps
module sched_raw_check #(
  parameter int NB = 8,
  parameter int AW = 32
) (
  input  logic [NB*AW-1:0] rd_addr,
  input  logic [NB-1:0]    wr_req,
  input  logic [NB*AW-1:0] wr_addr,
  output logic [NB-1:0]    raw_hit
);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic [AW-1:0] ra;
    logic          hit;
    assign ra = rd_addr[i*AW +: AW];
    always_comb begin
      hit = 1'b0;
      for (int j = 0; j < NB; j++)
        if (wr_req[j] && (wr_addr[j*AW +: AW] == ra)) hit = 1'b1;
    end
    assign raw_hit[i] = hit;
  end

endmodule

// File: rtl/dram_cmd_sched.sv
`timescale 1ns/1ps
module dram_cmd_sched
  import dram_sched_pkg::*;
#(
  parameter int NB     = 8,
  parameter int AW     = 32,
  parameter int REFW   = 13,
  parameter int SCRW   = 12,
  parameter int TFAW   = 16,
  parameter int MAXACT = 4,
  localparam int BW    = $clog2(NB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REFW-1:0]    cfg_ref_ivl,
  input  logic [SCRW-1:0]    cfg_scrub_ivl,
  input  logic [NB-1:0]      cas_req,
  input  logic [NB-1:0]      rd_req,
  input  logic [NB*AW-1:0]   rd_addr,
  input  logic [NB-1:0]      wr_req,
  input  logic [NB*AW-1:0]   wr_addr,
  output logic [2:0]         cmd_out,
  output logic [BW-1:0]      cmd_bank,
  output logic [NREQ-1:0]    grant
);

  function automatic logic [BW-1:0] lowest(input logic [NB-1:0] v);
    logic [BW-1:0] r;
    r = '0;
    for (int i = NB - 1; i >= 0; i--) if (v[i]) r = BW'(i);
    return r;
  endfunction

  function automatic logic [BW-1:0] next_bank(input logic [BW-1:0] b);
    return (b == BW'(NB - 1)) ? '0 : b + BW'(1);
  endfunction

  function automatic logic [NB-1:0] below_mask(input logic [BW-1:0] b);
    return (NB'(1) << b) - NB'(1);
  endfunction

  // named internal events
  logic            ref_due, scr_due, act_block, act_fire;
  logic [NB-1:0]   raw_hit, rd_ok;
  logic [BW-1:0]   scr_bank;
  logic [NREQ-1:0] grant_d;
  sched_cmd_e      cmd_d;
  logic [BW-1:0]   bank_d;

  sched_interval_timer #(.W(REFW)) u_ref_tmr (
    .clk(clk), .rst_n(rst_n), .reload(cfg_ref_ivl),
    .take(grant_d[G_REF]), .due(ref_due));

  sched_interval_timer #(.W(SCRW)) u_scr_tmr (
    .clk(clk), .rst_n(rst_n), .reload(cfg_scrub_ivl),
    .take(grant_d[G_SCRUB]), .due(scr_due));

  sched_act_window #(.WIN(TFAW), .LIMIT(MAXACT)) u_faw (
    .clk(clk), .rst_n(rst_n), .act_fire(act_fire), .act_block(act_block));

  sched_raw_check #(.NB(NB), .AW(AW)) u_raw (
    .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr), .raw_hit(raw_hit));

  assign rd_ok = rd_req & ~raw_hit;

  always_comb begin
    grant_d = '0;
    cmd_d   = CMD_NOP;
    bank_d  = '0;
    if (rst_n) begin
      if (ref_due) begin
        grant_d[G_REF] = 1'b1;
        cmd_d          = CMD_REF;
      end else if (|cas_req) begin
        grant_d[G_CAS] = 1'b1;
        cmd_d          = CMD_CAS;
        bank_d         = lowest(cas_req);
      end else if (scr_due) begin
        grant_d[G_SCRUB] = 1'b1;
        cmd_d            = CMD_SCRUB;
        bank_d           = scr_bank;
      end else if (!act_block && (|rd_ok)) begin
        grant_d[G_READ] = 1'b1;
        cmd_d           = CMD_ACT_RD;
        bank_d          = lowest(rd_ok);
      end else if (!act_block && (|wr_req)) begin
        grant_d[G_WRITE] = 1'b1;
        cmd_d            = CMD_ACT_WR;
        bank_d           = lowest(wr_req);
      end
    end
  end

  assign act_fire = grant_d[G_READ] | grant_d[G_WRITE];

  always_ff @(posedge clk) begin
    if (!rst_n)                 scr_bank <= '0;
    else if (grant_d[G_SCRUB])  scr_bank <= next_bank(scr_bank);
  end

  assign grant    = grant_d;
  assign cmd_out  = cmd_d;
  assign cmd_bank = bank_d;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_d));                                       // R1
  AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due |-> grant_d[G_REF]);                              // R2
  AST_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    grant_d[G_READ] |-> !raw_hit[bank_d]);                    // R6
  AST_LOW_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    grant_d[G_CAS] |-> (cas_req[bank_d] && ((cas_req & below_mask(bank_d)) == '0))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (grant_d == '0));                              // R8

endmodule

// File: tb/sim_dram_cmd_sched.sv
`timescale 1ns/1ps
module sim_dram_cmd_sched;

  localparam int NB = 8, AW = 32, REFW = 13, SCRW = 12, TFAW = 16, MAXACT = 4, BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [REFW-1:0]  cfg_ref;
  logic [SCRW-1:0]  cfg_scr;
  logic [NB-1:0]    cas_req, rd_req, wr_req;
  logic [NB*AW-1:0] rd_addr, wr_addr;
  logic [2:0]       cmd_out;
  logic [BW-1:0]    cmd_bank;
  logic [4:0]       grant;

  dram_cmd_sched u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ref_ivl(cfg_ref), .cfg_scrub_ivl(cfg_scr),
    .cas_req(cas_req), .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_addr(wr_addr),
    .cmd_out(cmd_out), .cmd_bank(cmd_bank), .grant(grant));

  int n_chk = 0, n_fail = 0;

  // bench model state
  int            m_ref, m_scr, m_sb;
  logic [TFAW-2:0] m_hist;
  // expectation
  logic [4:0] e_gnt;
  int         e_cmd, e_bank;
  string      e_tag;
  // host stimulus rates (percent per bank per cycle)
  int p_rw, p_cas;

  function automatic int pop(input logic [TFAW-2:0] v);
    int n = 0;
    foreach (v[i]) if (v[i]) n++;
    return n;
  endfunction

  function automatic int first(input logic [NB-1:0] v);
    for (int i = 0; i < NB; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit raw_blocked(input int i);
    for (int j = 0; j < NB; j++)
      if (wr_req[j] && wr_addr[j*AW +: AW] == rd_addr[i*AW +: AW]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [AW-1:0] pool_addr();
    return 32'hA000_0000 + 32'($urandom % 6) * 32'd64;
  endfunction

  task automatic predict();
    logic [NB-1:0] rok;
    bit blocked;
    for (int i = 0; i < NB; i++) rok[i] = rd_req[i] && !raw_blocked(i);
    blocked = pop(m_hist) >= MAXACT;
    e_gnt = '0; e_cmd = 0; e_bank = 0; e_tag = "R1";
    if (m_ref == 0) begin
      e_gnt = 5'b00001; e_cmd = 1; e_tag = "R3";
    end else if (cas_req != '0) begin
      e_gnt = 5'b00010; e_cmd = 2; e_bank = first(cas_req); e_tag = "R2";
    end else if (m_scr == 0) begin
      e_gnt = 5'b00100; e_cmd = 3; e_bank = m_sb; e_tag = "R4";
    end else if (!blocked && rok != '0) begin
      e_gnt = 5'b01000; e_cmd = 4; e_bank = first(rok);
      e_tag = (rok != rd_req) ? "R6" : "R7";
    end else if (!blocked && wr_req != '0) begin
      e_gnt = 5'b10000; e_cmd = 5; e_bank = first(wr_req);
      e_tag = (rd_req != '0) ? "R6" : "R7";
    end else if (blocked && (rd_req | wr_req) != '0) begin
      e_tag = "R5";
    end
  endtask

  task automatic compare();
    n_chk++;
    if (grant !== e_gnt || cmd_out !== 3'(e_cmd) || cmd_bank !== BW'(e_bank)) begin
      n_fail++;
      $display("FAIL %s t=%0t: grant=%b cmd=%0d bank=%0d expected grant=%b cmd=%0d bank=%0d",
               e_tag, $time, grant, cmd_out, cmd_bank, e_gnt, e_cmd, e_bank);
    end
  endtask

  task automatic advance_model();
    if (e_gnt[0]) m_ref = cfg_ref; else if (m_ref != 0) m_ref--;
    if (e_gnt[2]) begin m_scr = cfg_scr; m_sb = (m_sb + 1) % NB; end
    else if (m_scr != 0) m_scr--;
    m_hist = {m_hist[TFAW-3:0], e_gnt[3] | e_gnt[4]};
  endtask

  task automatic advance_host();
    if (e_gnt[1]) cas_req[e_bank] = 1'b0;
    if (e_gnt[3]) rd_req[e_bank]  = 1'b0;
    if (e_gnt[4]) wr_req[e_bank]  = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (!rd_req[b] && ($urandom % 100) < p_rw) begin
        rd_req[b] = 1'b1; rd_addr[b*AW +: AW] = pool_addr();
      end
      if (!wr_req[b] && ($urandom % 100) < p_rw) begin
        wr_req[b] = 1'b1; wr_addr[b*AW +: AW] = pool_addr();
      end
      if (!cas_req[b] && ($urandom % 100) < p_cas) cas_req[b] = 1'b1;
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      predict();
      compare();
      @(posedge clk);
      #1;
      advance_model();
      advance_host();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cfg_ref = 13'd37; cfg_scr = 12'd23;
    cas_req = '0; rd_req = '0; wr_req = '0; rd_addr = '0; wr_addr = '0;
    p_rw = 0; p_cas = 0;
    repeat (3) @(posedge clk);
    #1 cas_req = '1; rd_req = '1; wr_req = '1;
    @(negedge clk);
    n_chk++;  // R8: reset keeps grants off despite requests
    if (grant !== 5'b0 || cmd_out !== 3'd0) begin
      n_fail++;
      $display("FAIL R8: grant=%b cmd=%0d expected grant=00000 cmd=0", grant, cmd_out);
    end
    cas_req = '0; rd_req = '0; wr_req = '0;
    m_ref = cfg_ref; m_scr = cfg_scr; m_sb = 0; m_hist = '0;
    @(posedge clk);
    #1 rst_n = 1'b1;

    // quiet: timers alone (R3, R4 first due points)
    run(60);
    // read flood with distinct addresses fills the activate window (R5, R7)
    for (int b = 0; b < NB; b++) begin
      rd_req[b] = 1'b1; rd_addr[b*AW +: AW] = 32'hB000_0000 + 32'(b) * 32'h100;
    end
    run(70);
    // hazard: read 1 waits on write 2, read 5 overtakes (R6)
    wr_req[2] = 1'b1; wr_addr[2*AW +: AW] = 32'hC000_0040;
    rd_req[1] = 1'b1; rd_addr[1*AW +: AW] = 32'hC000_0040;
    rd_req[5] = 1'b1; rd_addr[5*AW +: AW] = 32'hC000_0080;
    run(40);
    // CAS burst across all banks against timers (R2, R7)
    cas_req = '1;
    run(30);
    // random traffic
    p_rw = 3; p_cas = 1;
    run(2500);
    p_rw = 8; p_cas = 2;
    run(1500);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL R1 watchdog: run not finished at t=%0t, expected completion earlier", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule